// File: doc/BRIEF.md
# Same-Index Routing Switch Box

This block sits where a horizontal routing channel meets a vertical one. Four sides (north, east, south, west) each carry `W` tracks. Every track is split into a separate input net and output net, so the block needs no bidirectional wires. A wire that enters on one side can be switched onto the track with the same index on any of the other three sides. No switch ever joins two different track indices. Each wire therefore owns three switches, and the box holds `12*W` of them. To build a long path, the switches are turned on in successive boxes, because each segment ends at the next box.

The switch settings arrive one bit per clock through a serial shift chain. A scan output lets several boxes be chained one after another. The settings that reach the routing are held in a separate active copy, and that copy changes only on a commit strobe. A half-loaded pattern therefore never reaches the tracks. The box also raises a flag for every output track that two or more enabled switches try to drive at the same time.

Top module: `planar_switch_box`

## Requirements
- R1: After reset the chain and the active configuration are all zero, so every output track and every conflict flag reads 0 whatever the inputs are.
- R2: While `cfg_shift` is high, the chain moves one place per clock toward the high index, `cfg_bit` enters at index 0, and `cfg_scan_out` shows the highest index; while `cfg_shift` is low the chain and `cfg_scan_out` hold.
- R3: Configuration bit `(s*3+d)*W + k` lets input track `k` of side `s` drive output track `k` of side `(s+1+d) mod 4`, with sides numbered north 0, east 1, south 2, west 3 and `d` in 0..2.
- R4: The active configuration copies the whole chain on a clock where `cfg_commit` is high and holds otherwise, so shifting without a commit leaves every output unchanged.
- R5: Output track `k` of a side is the OR of the same-index inputs of the other three sides, each gated by its enable, and reads 0 when none is enabled; it follows the inputs without a clock.
- R6: An input on track index `j` never affects an output on a different index `k`.
- R7: The conflict flag of output track `k` on a side is high exactly when two or three of its enables are set, whatever the data inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_shift | input | 1 | Shift enable of the configuration chain |
| cfg_bit | input | 1 | Serial configuration data in |
| cfg_commit | input | 1 | Copies the chain into the active switch settings |
| cfg_scan_out | output | 1 | Last chain stage, for daisy-chaining boxes |
| in_n | input | W | North side incoming tracks |
| in_e | input | W | East side incoming tracks |
| in_s | input | W | South side incoming tracks |
| in_w | input | W | West side incoming tracks |
| out_n | output | W | North side outgoing tracks |
| out_e | output | W | East side outgoing tracks |
| out_s | output | W | South side outgoing tracks |
| out_w | output | W | West side outgoing tracks |
| clash_n | output | W | North side per-track conflict flags |
| clash_e | output | W | East side per-track conflict flags |
| clash_s | output | W | South side per-track conflict flags |
| clash_w | output | W | West side per-track conflict flags |

## Verification
The bench builds the box with `W = 4`, which gives a 48-bit chain. That size is small enough for a scan-out walk, and it still gives several track indices, so leakage between indices would show up. With four tracks the bench can load random legal patterns, where each output has at most one source, and random unconstrained patterns, where double and triple drivers are common, so both flag cases occur. It also loads single-switch patterns that pin down the bit layout, and it shifts a second pattern in without a commit to show that the old routing holds.

// File: rtl/psb_pkg.sv
package psb_pkg;

   localparam int SIDES = 4;
   localparam int FANOUT = 3;

   typedef enum logic [1:0] {
      SIDE_N = 2'd0,
      SIDE_E = 2'd1,
      SIDE_S = 2'd2,
      SIDE_W = 2'd3
   } side_e;

   // direction slot d of source side src points at this side
   function automatic int dest_side(input int src, input int d);
      return (src + 1 + d) % SIDES;
   endfunction

   // slot that a source side uses to reach destination dst (dst != src)
   function automatic int slot_to(input int src, input int dst);
      return (dst - src + 3) % SIDES;
   endfunction

   function automatic int cfg_index(input int src, input int d, input int k, input int w);
      return (src * FANOUT + d) * w + k;
   endfunction

endpackage

// File: rtl/psb_cfg_chain.sv
module psb_cfg_chain #(
   parameter int NBITS = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             bit_in,
   input  logic             commit,
   output logic             scan_out,
   output logic [NBITS-1:0] active
);

   logic [NBITS-1:0] shadow;

   generate
      if (NBITS < 2) begin : g_len_bad
         $error("psb_cfg_chain: NBITS must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '0;
      end else if (shift_en) begin
         shadow <= {shadow[NBITS-2:0], bit_in};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= '0;
      end else if (commit) begin
         active <= shadow;
      end
   end

   assign scan_out = shadow[NBITS-1];

endmodule

// File: rtl/psb_track_node.sv
module psb_track_node #(
   parameter int FAN = 3
) (
   input  logic [FAN-1:0] src_bit,
   input  logic [FAN-1:0] src_en,
   output logic           drive,
   output logic           clash
);

   logic [FAN-1:0] gated;
   logic [FAN-1:0] pair_hit;

   generate
      if (FAN != 3) begin : g_fan_bad
         $error("psb_track_node: planar box needs exactly three sources");
      end
   endgenerate

   assign gated = src_bit & src_en;

   // pairwise overlap of enables: any pair set means two drivers
   genvar p;
   generate
      for (p = 0; p < FAN; p++) begin : g_pair
         assign pair_hit[p] = src_en[p] & src_en[(p + 1) % FAN];
      end
   endgenerate

   assign drive = |gated;
   assign clash = |pair_hit;

endmodule

// File: rtl/planar_switch_box.sv
module planar_switch_box
   import psb_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cfg_shift,
   input  logic         cfg_bit,
   input  logic         cfg_commit,
   output logic         cfg_scan_out,
   input  logic [W-1:0] in_n,
   input  logic [W-1:0] in_e,
   input  logic [W-1:0] in_s,
   input  logic [W-1:0] in_w,
   output logic [W-1:0] out_n,
   output logic [W-1:0] out_e,
   output logic [W-1:0] out_s,
   output logic [W-1:0] out_w,
   output logic [W-1:0] clash_n,
   output logic [W-1:0] clash_e,
   output logic [W-1:0] clash_s,
   output logic [W-1:0] clash_w
);

   localparam int NBITS = SIDES * FANOUT * W;

   generate
      if (W < 1) begin : g_w_bad
         $error("planar_switch_box: W must be at least 1");
      end
   endgenerate

   logic [NBITS-1:0]         act_cfg;
   logic [SIDES-1:0][W-1:0]  in_arr;
   logic [SIDES-1:0][W-1:0]  out_arr;
   logic [SIDES-1:0][W-1:0]  clash_arr;

   assign in_arr = {in_w, in_s, in_e, in_n};

   psb_cfg_chain #(
      .NBITS(NBITS)
   ) u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(cfg_shift),
      .bit_in  (cfg_bit),
      .commit  (cfg_commit),
      .scan_out(cfg_scan_out),
      .active  (act_cfg)
   );

   genvar t, k, j;
   generate
      for (t = 0; t < SIDES; t++) begin : g_side
         for (k = 0; k < W; k++) begin : g_trk
            logic [FANOUT-1:0] nb_bit;
            logic [FANOUT-1:0] nb_en;
            for (j = 0; j < FANOUT; j++) begin : g_src
               localparam int SRC = (t + 1 + j) % SIDES;
               localparam int IDX = cfg_index(SRC, slot_to(SRC, t), k, W);
               assign nb_bit[j] = in_arr[SRC][k];
               assign nb_en[j]  = act_cfg[IDX];
            end
            psb_track_node #(
               .FAN(FANOUT)
            ) u_node (
               .src_bit(nb_bit),
               .src_en (nb_en),
               .drive  (out_arr[t][k]),
               .clash  (clash_arr[t][k])
            );
         end
      end
   endgenerate

   assign out_n   = out_arr[SIDE_N];
   assign out_e   = out_arr[SIDE_E];
   assign out_s   = out_arr[SIDE_S];
   assign out_w   = out_arr[SIDE_W];
   assign clash_n = clash_arr[SIDE_N];
   assign clash_e = clash_arr[SIDE_E];
   assign clash_s = clash_arr[SIDE_S];
   assign clash_w = clash_arr[SIDE_W];

endmodule

// File: rtl/psb_checker.sv
module psb_checker #(
   parameter int W = 8,
   parameter int NBITS = 96
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_shift,
   input logic             cfg_commit,
   input logic             cfg_scan_out,
   input logic [NBITS-1:0] act_cfg,
   input logic [W-1:0]     in_n,
   input logic [W-1:0]     in_e,
   input logic [W-1:0]     in_s,
   input logic [W-1:0]     in_w,
   input logic [W-1:0]     out_n,
   input logic [W-1:0]     out_e,
   input logic [W-1:0]     out_s,
   input logic [W-1:0]     out_w,
   input logic [W-1:0]     clash_n,
   input logic [W-1:0]     clash_e,
   input logic [W-1:0]     clash_s,
   input logic [W-1:0]     clash_w
);

   // R4
   act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_commit |=> $stable(act_cfg));

   // R2
   scan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_shift |=> $stable(cfg_scan_out));

   // R6
   same_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((out_n & ~(in_e | in_s | in_w)) == '0) &&
      ((out_e & ~(in_n | in_s | in_w)) == '0) &&
      ((out_s & ~(in_n | in_e | in_w)) == '0) &&
      ((out_w & ~(in_n | in_e | in_s)) == '0));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_cfg == '0) |->
         ({out_n, out_e, out_s, out_w, clash_n, clash_e, clash_s, clash_w} == '0));

endmodule

bind planar_switch_box psb_checker #(
   .W    (W),
   .NBITS(NBITS)
) u_psb_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_shift   (cfg_shift),
   .cfg_commit  (cfg_commit),
   .cfg_scan_out(cfg_scan_out),
   .act_cfg     (act_cfg),
   .in_n        (in_n),
   .in_e        (in_e),
   .in_s        (in_s),
   .in_w        (in_w),
   .out_n       (out_n),
   .out_e       (out_e),
   .out_s       (out_s),
   .out_w       (out_w),
   .clash_n     (clash_n),
   .clash_e     (clash_e),
   .clash_s     (clash_s),
   .clash_w     (clash_w)
);

// File: tb/planar_switch_box_bench.sv
module planar_switch_box_bench;

   localparam int W  = 4;
   localparam int NB = 12 * W;

   typedef logic [3:0][W-1:0] grid_t;

   typedef struct {
      grid_t o;
      grid_t c;
      string tag;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_shift = 1'b0;
   logic cfg_bit = 1'b0;
   logic cfg_commit = 1'b0;
   logic cfg_scan_out;
   logic [W-1:0] in_n = '0, in_e = '0, in_s = '0, in_w = '0;
   logic [W-1:0] out_n, out_e, out_s, out_w;
   logic [W-1:0] clash_n, clash_e, clash_s, clash_w;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [NB-1:0] sh_model  = '0;
   logic [NB-1:0] act_model = '0;
   item_t sb_q[$];

   always #4 clk = ~clk;

   planar_switch_box #(.W(W)) u_planar_switch_box (
      .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_bit(cfg_bit),
      .cfg_commit(cfg_commit), .cfg_scan_out(cfg_scan_out),
      .in_n(in_n), .in_e(in_e), .in_s(in_s), .in_w(in_w),
      .out_n(out_n), .out_e(out_e), .out_s(out_s), .out_w(out_w),
      .clash_n(clash_n), .clash_e(clash_e), .clash_s(clash_s), .clash_w(clash_w)
   );

   function automatic void model(input logic [NB-1:0] c, input grid_t ins,
                                 output grid_t o, output grid_t cf);
      o = '0;
      cf = '0;
      for (int t = 0; t < 4; t++) begin
         for (int k = 0; k < W; k++) begin
            int n_en = 0;
            for (int s = 0; s < 4; s++) begin
               if (s != t) begin
                  int d = (t - s + 3) % 4;
                  if (c[(s * 3 + d) * W + k]) begin
                     n_en++;
                     if (ins[s][k]) o[t][k] = 1'b1;
                  end
               end
            end
            cf[t][k] = (n_en >= 2);
         end
      end
   endfunction

   task automatic check_bit(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   // driver: apply a data pattern and post the expected result
   task automatic drive(input grid_t ins, input string tag);
      item_t it;
      @(posedge clk);
      #1;
      in_n = ins[0];
      in_e = ins[1];
      in_s = ins[2];
      in_w = ins[3];
      model(act_model, ins, it.o, it.c);
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   // monitor: compare at the falling edge
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         item_t it;
         grid_t go, gc;
         it = sb_q.pop_front();
         go = {out_w, out_s, out_e, out_n};
         gc = {clash_w, clash_s, clash_e, clash_n};
         checks++;
         if (go !== it.o) begin
            errors++;
            $display("FAIL %s outputs: got %h expected %h", it.tag, go, it.o);
         end
         checks++;
         if (gc !== it.c) begin
            errors++;
            $display("FAIL %s conflicts: got %h expected %h", it.tag, gc, it.c);
         end
      end
   end

   task automatic shift_in(input logic [NB-1:0] bits, input int count);
      for (int i = count - 1; i >= 0; i--) begin
         @(posedge clk);
         #1;
         cfg_shift = 1'b1;
         cfg_bit = bits[i];
      end
      @(posedge clk);
      #1;
      cfg_shift = 1'b0;
      for (int i = count - 1; i >= 0; i--) sh_model = {sh_model[NB-2:0], bits[i]};
   endtask

   task automatic commit_cfg();
      @(posedge clk);
      #1;
      cfg_commit = 1'b1;
      @(posedge clk);
      #1;
      cfg_commit = 1'b0;
      act_model = sh_model;
   endtask

   task automatic load(input logic [NB-1:0] bits);
      shift_in(bits, NB);
      commit_cfg();
   endtask

   function automatic grid_t rand_grid();
      grid_t g;
      for (int s = 0; s < 4; s++) g[s] = W'($urandom);
      return g;
   endfunction

   function automatic logic [NB-1:0] rand_legal();
      logic [NB-1:0] c = '0;
      for (int t = 0; t < 4; t++) begin
         for (int k = 0; k < W; k++) begin
            int r = int'($urandom % 4);
            if (r < 3) begin
               int s = (t + 1 + r) % 4;
               c[(s * 3 + (t - s + 3) % 4) * W + k] = 1'b1;
            end
         end
      end
      return c;
   endfunction

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [NB-1:0] cfg_a, cfg_b;
      grid_t g;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;

      // R1: nothing routes after reset
      drive('1, "R1 reset all-ones inputs");
      drive(rand_grid(), "R1 reset random inputs");

      // R3: single switches pin down the bit layout
      for (int s = 0; s < 4; s++) begin
         for (int d = 0; d < 3; d++) begin
            int k = (s + d) % W;
            load(NB'(1) << ((s * 3 + d) * W + k));
            g = '0;
            g[s][k] = 1'b1;
            drive(g, "R3 single switch");
            // R6: every other index high, nothing may leak
            g = '1;
            g[s][k] = 1'b0;
            drive(g, "R6 other indices");
         end
      end

      // R5 R6: random legal patterns
      for (int n = 0; n < 20; n++) begin
         load(rand_legal());
         for (int v = 0; v < 8; v++) drive(rand_grid(), "R5 legal routing");
      end

      // R7: unconstrained patterns, flags independent of data
      for (int n = 0; n < 12; n++) begin
         load({$urandom, $urandom});
         drive('0, "R7 conflicts zero data");
         drive('1, "R7 conflicts ones data");
         drive(rand_grid(), "R7 conflicts random data");
      end
      load('1);
      drive(rand_grid(), "R7 all switches on");

      // R4 R2: shift a new pattern without commit
      cfg_a = rand_legal();
      load(cfg_a);
      cfg_b = {$urandom, $urandom};
      shift_in(cfg_b, NB);
      check_bit(cfg_scan_out, cfg_b[NB-1], "R2 scan out top bit");
      for (int v = 0; v < 4; v++) drive(rand_grid(), "R4 uncommitted load");
      @(posedge clk);
      #1;
      check_bit(cfg_scan_out, cfg_b[NB-1], "R2 hold without shift");
      shift_in(1'b0, 1);
      check_bit(cfg_scan_out, cfg_b[NB-2], "R2 scan out next bit");
      commit_cfg();
      for (int v = 0; v < 4; v++) drive(rand_grid(), "R4 committed load");

      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule